// File: doc/BRIEF.md
# Sampling Converter Sequencer with Power-Down Control

This block runs a serial sampling converter from the host side. It drives the converter's start line and serial clock, and it collects one result per programmed sample period. Each result is presented on a data bus with a single-cycle valid strobe. A mode input picks between two start-line waveforms. In low-power mode, the line is raised to wake the converter, lowered to convert, and then left low, so the converter sleeps between samples. In fast mode, the line is lowered only briefly to launch a conversion, then raised again and kept high, so the converter stays awake.

Every sample cycle has the same slots: wake-up, conversion, serial read and idle fill. The read begins only once the conversion time after the start-line fall has elapsed, so the word shifted in is the current result. If the requested period is too short to hold all the slots, it is stretched to the shortest legal length and an error flag is raised. A result that arrives while the previous one is still unacknowledged raises an overrun flag. Mode and period are sampled at the start of each cycle.

Top module: `sample_sequencer`

## Requirements
- R1: While reset is asserted, and from the second clock edge after `enable` goes low, `startPin` and `sclk` are low, and `overrun` and `periodErr` are cleared.
- R2: In low-power mode (`lowPowerMode`=1), each cycle holds `startPin` high for exactly PWRUP_CYC clocks. It then holds the pin low until the next cycle begins, so the pin is low when the conversion completes.
- R3: In fast mode (`lowPowerMode`=0), `startPin` returns high exactly LOW_CYC clocks after each falling edge (LOW_CYC < CONV_CYC). It stays high through the end of conversion and until the next fall.
- R4: The first rising edge of `sclk` in a cycle comes exactly CONV_CYC + SCLK_DIV clocks after the falling edge of `startPin`.
- R5: Each sample uses exactly DATA_W `sclk` pulses. Each pulse is high for SCLK_DIV clocks and is separated from the next by SCLK_DIV low clocks. `dataIn` is captured on the clock edge where `sclk` rises.
- R6: `sampleData` holds the DATA_W bits captured in that cycle, with the first captured bit in the MSB position. `sampleValid` is high for exactly one clock per sample.
- R7: Successive falling edges of `startPin` are spaced by max(`periodCfg`, MIN_PERIOD) clocks, where MIN_PERIOD = PWRUP_CYC + CONV_CYC + 2·DATA_W·SCLK_DIV + 1.
- R8: `periodErr` is set when a cycle begins with `periodCfg` < MIN_PERIOD. It stays set until `enable` goes low.
- R9: `overrun` is set when a new result is delivered while the previous one has not been acknowledged by a `sampleAck` pulse. It stays set until `enable` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run sampling cycles while high |
| lowPowerMode | input | 1 | 1: converter sleeps between samples, 0: converter kept awake |
| periodCfg | input | PERIOD_W | Requested sample period in clocks |
| sampleAck | input | 1 | Pulse acknowledging the last delivered result |
| dataIn | input | 1 | Serial data from the converter |
| startPin | output | 1 | Converter start / wake line |
| sclk | output | 1 | Serial clock to the converter |
| sampleValid | output | 1 | One-clock strobe with each new result |
| sampleData | output | DATA_W | Latest result, MSB first in time |
| overrun | output | 1 | Sticky: result delivered before the previous one was acknowledged |
| periodErr | output | 1 | Sticky: the programmed period was stretched to the minimum |

## Verification
Two situations are hard to reach from the ports: a period request below the minimum, and a result dropped for lack of an acknowledge. The stimulus reaches them with directed phases that program a period below the floor and exactly at it, and with phases whose acknowledge driver is switched off. A behavioural converter model in the bench latches a fresh word a conversion time after each start-line fall. It also records the start-line level at that moment, so an early read or a power-down in fast mode would be caught. Randomised phases then mix modes, periods around the floor and sample counts from a fixed seed.

// File: rtl/sample_seq_pkg.sv
`timescale 1ns/1ps
package sample_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_CONV,
    ST_READ,
    ST_WAIT
  } seq_state_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic pinHigh;
    logic sclkHigh;
    logic shiftEn;
    logic emit;
    logic clrFlags;
  } seq_ctl_t;

endpackage

// File: rtl/sample_seq_ctrl.sv
`timescale 1ns/1ps
module sample_seq_ctrl
  import sample_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SCLK_DIV  = 2,
  parameter int PWRUP_CYC = 300,
  parameter int CONV_CYC  = 1000,
  parameter int LOW_CYC   = 100,
  parameter int PERIOD_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                lowPowerMode,
  input  logic [PERIOD_W-1:0] periodCfg,
  output seq_ctl_t            ctl,
  output logic                periodErr
);

  localparam int READ_CYC   = 2 * DATA_W * SCLK_DIV;
  localparam int MIN_PERIOD = PWRUP_CYC + CONV_CYC + READ_CYC + 1;
  localparam int PH_MAX     = (PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC;
  localparam int PH_W       = $clog2(PH_MAX + 1);
  localparam int HALF_W     = $clog2(2 * DATA_W);
  localparam int DV_W       = $clog2(SCLK_DIV + 1);

  seq_state_t          state;
  logic [PH_W-1:0]     phaseCnt;
  logic [HALF_W-1:0]   halfCnt;
  logic [DV_W-1:0]     divCnt;
  logic [PERIOD_W-1:0] periodCnt;
  logic [PERIOD_W-1:0] effPer;
  logic                modeLp;
  logic                cfgTooShort;
  logic                wrapNow;

  assign cfgTooShort = periodCfg < PERIOD_W'(MIN_PERIOD);
  assign wrapNow     = (state == ST_WAIT) && (periodCnt == effPer - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phaseCnt  <= '0;
      halfCnt   <= '0;
      divCnt    <= '0;
      periodCnt <= '0;
      effPer    <= PERIOD_W'(MIN_PERIOD);
      modeLp    <= 1'b0;
      periodErr <= 1'b0;
    end else if (!enable) begin
      state     <= ST_IDLE;
      phaseCnt  <= '0;
      halfCnt   <= '0;
      divCnt    <= '0;
      periodCnt <= '0;
      periodErr <= 1'b0;
    end else if (state == ST_IDLE || wrapNow) begin
      // new sample cycle: latch configuration
      state     <= ST_WAKE;
      phaseCnt  <= '0;
      periodCnt <= '0;
      modeLp    <= lowPowerMode;
      effPer    <= cfgTooShort ? PERIOD_W'(MIN_PERIOD) : periodCfg;
      if (cfgTooShort) periodErr <= 1'b1;
    end else begin
      periodCnt <= periodCnt + 1'b1;
      case (state)
        ST_WAKE: begin
          if (phaseCnt == PH_W'(PWRUP_CYC - 1)) begin
            state    <= ST_CONV;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_CONV: begin
          if (phaseCnt == PH_W'(CONV_CYC - 1)) begin
            state   <= ST_READ;
            halfCnt <= '0;
            divCnt  <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_READ: begin
          if (divCnt == DV_W'(SCLK_DIV - 1)) begin
            divCnt <= '0;
            if (halfCnt == HALF_W'(2 * DATA_W - 1)) begin
              state    <= ST_WAIT;
              phaseCnt <= '0;
            end else begin
              halfCnt <= halfCnt + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_WAIT: phaseCnt <= PH_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl = '0;
    ctl.clrFlags = !enable;
    case (state)
      ST_WAKE: ctl.pinHigh = 1'b1;
      ST_CONV: ctl.pinHigh = !modeLp && (phaseCnt >= PH_W'(LOW_CYC));
      ST_READ: begin
        ctl.pinHigh  = !modeLp;
        ctl.sclkHigh = halfCnt[0];
        ctl.shiftEn  = halfCnt[0] && (divCnt == '0);
      end
      ST_WAIT: begin
        ctl.pinHigh = !modeLp;
        ctl.emit    = (phaseCnt == '0);
      end
      default: ctl.pinHigh = 1'b0;
    endcase
  end

  // R1: dropping enable returns the sequencer to idle
  assert_disable_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (state == ST_IDLE));

  // R7: the effective period never falls below the floor while running
  assert_period_floor_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (effPer >= PERIOD_W'(MIN_PERIOD)));

  // R7: the period counter stays inside the latched period
  assert_period_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (periodCnt < effPer));

endmodule

// File: rtl/sample_seq_dp.sv
`timescale 1ns/1ps
module sample_seq_dp
  import sample_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_ctl_t          ctl,
  input  logic              dataIn,
  input  logic              sampleAck,
  output logic              startPin,
  output logic              sclk,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleData,
  output logic              overrun
);

  logic [DATA_W-1:0] shiftReg;
  logic              pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPin    <= 1'b0;
      sclk        <= 1'b0;
      shiftReg    <= '0;
      sampleValid <= 1'b0;
      sampleData  <= '0;
      pending     <= 1'b0;
      overrun     <= 1'b0;
    end else begin
      startPin    <= ctl.pinHigh;
      sclk        <= ctl.sclkHigh;
      sampleValid <= ctl.emit;
      if (ctl.shiftEn) shiftReg <= {shiftReg[DATA_W-2:0], dataIn};
      if (ctl.clrFlags) begin
        pending <= 1'b0;
        overrun <= 1'b0;
      end else if (ctl.emit) begin
        sampleData <= shiftReg;
        pending    <= 1'b1;
        if (pending && !sampleAck) overrun <= 1'b1;
      end else if (sampleAck) begin
        pending <= 1'b0;
      end
    end
  end

  // R6: a result strobe lasts a single clock
  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R9: overrun is sticky until the flags are cleared
  assert_overrun_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !ctl.clrFlags) |=> overrun);

  // R5: every serial clock rise coincides with a data capture
  assert_capture_on_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> $past(ctl.shiftEn));

endmodule

// File: rtl/sample_sequencer.sv
`timescale 1ns/1ps
module sample_sequencer
  import sample_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SCLK_DIV  = 2,
  parameter int PWRUP_CYC = 300,
  parameter int CONV_CYC  = 1000,
  parameter int LOW_CYC   = 100,
  parameter int PERIOD_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                lowPowerMode,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic                sampleAck,
  input  logic                dataIn,
  output logic                startPin,
  output logic                sclk,
  output logic                sampleValid,
  output logic [DATA_W-1:0]   sampleData,
  output logic                overrun,
  output logic                periodErr
);

  seq_ctl_t ctlBus;

  sample_seq_ctrl #(
    .DATA_W(DATA_W), .SCLK_DIV(SCLK_DIV), .PWRUP_CYC(PWRUP_CYC),
    .CONV_CYC(CONV_CYC), .LOW_CYC(LOW_CYC), .PERIOD_W(PERIOD_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .lowPowerMode(lowPowerMode),
    .periodCfg(periodCfg), .ctl(ctlBus), .periodErr(periodErr)
  );

  sample_seq_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .dataIn(dataIn),
    .sampleAck(sampleAck), .startPin(startPin), .sclk(sclk),
    .sampleValid(sampleValid), .sampleData(sampleData), .overrun(overrun)
  );

endmodule

// File: tb/sample_sequencer_bench.sv
`timescale 1ns/1ps
module sample_sequencer_bench;

  localparam int DW = 8, DIV = 2, PW = 15, CV = 40, LO = 8, PERW = 12;
  localparam int MINP = PW + CV + 2 * DW * DIV + 1;

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0, lowPowerMode = 1'b0;
  logic [PERW-1:0] periodCfg = '0;
  logic sampleAck = 1'b0, dataIn;
  logic startPin, sclk, sampleValid, overrun, periodErr;
  logic [DW-1:0] sampleData;

  always #2.5 clk = ~clk;

  sample_sequencer #(.DATA_W(DW), .SCLK_DIV(DIV), .PWRUP_CYC(PW), .CONV_CYC(CV),
    .LOW_CYC(LO), .PERIOD_W(PERW)) u_sample_sequencer (
    .clk(clk), .rstN(rstN), .enable(enable), .lowPowerMode(lowPowerMode),
    .periodCfg(periodCfg), .sampleAck(sampleAck), .dataIn(dataIn),
    .startPin(startPin), .sclk(sclk), .sampleValid(sampleValid),
    .sampleData(sampleData), .overrun(overrun), .periodErr(periodErr));

  int total = 0, bad = 0;

  function automatic logic [DW-1:0] wordFn(int n);
    return DW'((n * 73 + 29) ^ (n >> 2));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural converter: latches a new word CV clocks after the start fall
  logic [DW-1:0] stubWord = '0;
  logic [2:0]    bitIdx = '0;
  logic          stubPrevPin = 1'b0, stubPrevSclk = 1'b0;
  int            stubCnt = 0, convIdx = 0;
  assign dataIn = stubWord[3'd7 - bitIdx];

  always @(posedge clk) begin
    stubPrevPin  <= startPin;
    stubPrevSclk <= sclk;
    if (sclk && !stubPrevSclk) bitIdx <= bitIdx + 1'b1;
    if (stubPrevPin && !startPin) stubCnt <= 1;
    else if (stubCnt != 0) begin
      if (stubCnt == CV - 1) begin
        stubWord <= wordFn(convIdx);
        convIdx  <= convIdx + 1;
        bitIdx   <= '0;
        stubCnt  <= 0;
      end else stubCnt <= stubCnt + 1;
    end
  end

  // monitor, sampled on the falling clock edge
  bit monOn = 0, expLp = 0;
  int expPer = MINP, cyc = 0, fallCyc = -1, riseCyc = -1;
  int sclkRiseCyc = 0, sclkFallCyc = 0, pulses = 0, validCnt = 0, seenConv = 0;
  logic prevPin = 1'b0, prevSclk = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!monOn) begin
      fallCyc = -1; riseCyc = -1; pulses = 0;
    end else begin
      if (prevPin && !startPin) begin
        if (fallCyc >= 0) check(cyc - fallCyc == expPer, "R7 fall spacing", cyc - fallCyc, expPer);
        if (expLp && riseCyc >= 0) check(cyc - riseCyc == PW, "R2 wake width", cyc - riseCyc, PW);
        fallCyc = cyc; pulses = 0;
      end
      if (!prevPin && startPin) begin
        if (fallCyc >= 0) begin
          if (expLp) check(cyc - fallCyc == expPer - PW, "R2 low span", cyc - fallCyc, expPer - PW);
          else check(cyc - fallCyc == LO, "R3 low pulse", cyc - fallCyc, LO);
        end
        riseCyc = cyc;
      end
      if (!prevSclk && sclk) begin
        if (pulses == 0) check(cyc - fallCyc == CV + DIV, "R4 read delay", cyc - fallCyc, CV + DIV);
        else check(cyc - sclkFallCyc == DIV, "R5 sclk low", cyc - sclkFallCyc, DIV);
        pulses++; sclkRiseCyc = cyc;
      end
      if (prevSclk && !sclk) begin
        check(cyc - sclkRiseCyc == DIV, "R5 sclk high", cyc - sclkRiseCyc, DIV);
        sclkFallCyc = cyc;
      end
      if (convIdx != seenConv && fallCyc >= 0)
        check(startPin == !expLp, "R3/R2 pin at conversion end", startPin, !expLp);
      if (sampleValid) begin
        check(sampleData == wordFn(convIdx - 1), "R6 data", sampleData, wordFn(convIdx - 1));
        check(pulses == DW, "R5 pulse count", pulses, DW);
        validCnt++;
      end
    end
    seenConv = convIdx;
    prevPin = startPin; prevSclk = sclk;
  end

  // acknowledge driver
  bit ackOn = 1;
  initial forever begin
    @(negedge clk);
    sampleAck <= ackOn && sampleValid;
  end

  task automatic runPhase(bit lp, int per, int n, bit ack);
    int startV;
    expLp = lp;
    expPer = (per < MINP) ? MINP : per;
    lowPowerMode = lp;
    periodCfg = PERW'(per);
    ackOn = ack;
    @(negedge clk);
    monOn = 1; enable = 1'b1;
    startV = validCnt;
    while (validCnt - startV < n) @(negedge clk);
    @(negedge clk);
    check(periodErr == (per < MINP), "R8 period error", periodErr, per < MINP);
    check(overrun == (!ack && n >= 2), "R9 overrun", overrun, !ack && n >= 2);
    monOn = 0; enable = 1'b0;
    repeat (3) @(negedge clk);
    check(startPin == 1'b0 && sclk == 1'b0, "R1 lines low after disable", {startPin, sclk}, 0);
    check(overrun == 1'b0 && periodErr == 1'b0, "R1/R9/R8 flags cleared", {overrun, periodErr}, 0);
    repeat (100) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    check(startPin == 1'b0 && sclk == 1'b0 && sampleValid == 1'b0, "R1 reset lines", {startPin, sclk, sampleValid}, 0);
    check(overrun == 1'b0 && periodErr == 1'b0, "R1 reset flags", {overrun, periodErr}, 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    check(startPin == 1'b0, "R1 idle before enable", startPin, 0);
    runPhase(1, 120, 4, 1);
    runPhase(0, 100, 4, 1);
    runPhase(1, 50, 3, 1);
    runPhase(0, MINP, 3, 1);
    runPhase(1, MINP, 2, 0);
    runPhase(0, 200, 3, 0);
    for (int i = 0; i < 6; i++) begin
      runPhase(bit'($urandom % 2), MINP - 12 + int'($urandom % 90), 2 + int'($urandom % 3), 1);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule